// File: doc/BRIEF.md
# I3C Target Common Command Decoder

This block sits behind an I3C target's bus front end and handles the bus-wide and addressed common commands sent by the controller. The front end hands it one command byte at a time, followed by any write data bytes and any read byte requests. It also supplies an indication that an addressed command matched this target, and a marker for the end of the transfer. The block keeps the last command byte in a register that firmware can read. For each accepted command it pulses either a supported or an unsupported interrupt flag. It applies the configuration that the command carries to the registers it owns: event enables, dynamic address, maximum read and write lengths, and in-band interrupt payload size.

For the read-type commands it returns response bytes one request at a time. A byte counter steps through multi-byte answers and restarts with every new command. The block also forwards the front end's static-address and dynamic-address match indications as flags, and holds them quiet while a command transfer is in progress. This lets firmware tell a plain private transfer apart from command traffic.

Top module: `i3c_ccc_decoder`

## Requirements
- R1: Every received command byte (cmd_valid high) is copied to ccc_code on the next clock edge, whether the code is supported or not and whether or not the address matched. After reset ccc_code is 0x00.
- R2: An accepted command raises exactly one of sup_irq and unsup_irq, as a pulse one cycle long on the edge after cmd_valid. sup_irq is raised for the bus-wide codes 0x00, 0x01, 0x06, 0x07, 0x09, 0x0A, 0x0C, 0x2A and for the addressed codes 0x80, 0x81, 0x86, 0x88, 0x89, 0x8A, 0x8B, 0x8C, 0x8D, 0x8E, 0x8F, 0x90, 0x94, 0x9A. unsup_irq is raised for every other code.
- R3: Codes 0x00-0x7F are bus-wide and are always accepted. Codes 0x80-0xFF are addressed and are accepted only when addr_hit is high with cmd_valid. A command that is not accepted raises no interrupt, changes no configuration register and answers every read request with 0x00. The same holds after xfer_end.
- R4: sa_flag and da_flag follow sa_hit_in and da_hit_in one edge later, but are forced low for a hit presented with cmd_valid or while a command transfer is open. A transfer opens at cmd_valid and closes at xfer_end.
- R5: The enable-events codes (0x00/0x80) set, and the disable-events codes (0x01/0x81) clear, the in-band interrupt enable (data bit 0) and the hot-join enable (data bit 3) named in the first data byte. Other bits and later bytes are ignored.
- R6: The reset-address codes 0x06 and 0x86, when accepted, clear dyn_addr to 0 and dyn_addr_valid to 0 on the edge after cmd_valid.
- R7: For code 0x88, the first data byte carries the new address in bits 7:1. dyn_addr takes those bits and dyn_addr_valid becomes 1.
- R8: For 0x0A/0x8A, data bytes 0 and 1 form max_rd_len, most significant byte first, and an optional byte 2 sets ibi_size. For 0x09/0x89, bytes 0 and 1 form max_wr_len. Further bytes are ignored, and writes under any other code change nothing.
- R9: For code 0x8C, the read bytes are max_rd_len high, max_rd_len low, then ibi_size. For code 0x8B, the read bytes are max_wr_len high, then low.
- R10: Code 0x8D returns the six prov_id bytes, most significant first. Code 0x8E returns bus_char, 0x8F returns dev_char, and 0x90 returns dev_status high then low.
- R11: rd_data and a one-cycle rd_valid appear on the edge after rd_req. The byte position restarts at 0 on every cmd_valid. Requests past the end of a response, and requests under codes without a response (for example 0x94 or 0x3F), return 0x00.
- R12: After reset, ibi_en and hj_en are 1, dyn_addr is 0 and not valid, max_rd_len and max_wr_len are 0x0100, ibi_size is 0x00, and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command byte strobe from the front end |
| cmd_code | input | 8 | Command byte |
| addr_hit | input | 1 | Addressed command matched this target (sampled with cmd_valid) |
| wr_valid | input | 1 | Write data byte strobe |
| wr_data | input | 8 | Write data byte |
| rd_req | input | 1 | Request for the next response byte |
| xfer_end | input | 1 | Command transfer finished |
| sa_hit_in | input | 1 | Static address match from the front end |
| da_hit_in | input | 1 | Dynamic address match from the front end |
| prov_id | input | 48 | Provisional ID value |
| bus_char | input | 8 | Bus characteristics byte |
| dev_char | input | 8 | Device characteristics byte |
| dev_status | input | 16 | Device status, two bytes |
| ccc_code | output | 8 | Last received command byte |
| sup_irq | output | 1 | Supported command pulse |
| unsup_irq | output | 1 | Unsupported command pulse |
| sa_flag | output | 1 | Static address match flag |
| da_flag | output | 1 | Dynamic address match flag |
| ibi_en | output | 1 | In-band interrupt enable |
| hj_en | output | 1 | Hot-join enable |
| dyn_addr | output | 7 | Dynamic address |
| dyn_addr_valid | output | 1 | Dynamic address assigned |
| max_rd_len | output | 16 | Maximum read length |
| max_wr_len | output | 16 | Maximum write length |
| ibi_size | output | 8 | In-band interrupt payload size |
| rd_data | output | 8 | Response byte |
| rd_valid | output | 1 | Response byte strobe |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it:
- ccc_code and the interrupt pulses follow cmd_valid;
- configuration registers follow wr_valid, except reset-address, which follows cmd_valid;
- rd_data and rd_valid follow rd_req;
- the match flags follow the front end's hit inputs.

The bench drives every strobe for one cycle from a falling edge and samples at the next falling edge. Each check therefore lands in the single cycle where a pulse is high, or where a register has just changed. Ignored stimulus is judged by reading the affected register or response byte back through the ports before the next command.

// File: rtl/i3c_ccc_pkg.sv
package i3c_ccc_pkg;

  localparam int BYTE_W = 8;

  // codes whose behaviour this block implements (others only flagged)
  localparam logic [7:0] OP_EVT_ON_B   = 8'h00;
  localparam logic [7:0] OP_EVT_OFF_B  = 8'h01;
  localparam logic [7:0] OP_ADDR_CLR_B = 8'h06;
  localparam logic [7:0] OP_WLEN_B     = 8'h09;
  localparam logic [7:0] OP_RLEN_B     = 8'h0A;
  localparam logic [7:0] OP_EVT_ON_D   = 8'h80;
  localparam logic [7:0] OP_EVT_OFF_D  = 8'h81;
  localparam logic [7:0] OP_ADDR_CLR_D = 8'h86;
  localparam logic [7:0] OP_ADDR_NEW   = 8'h88;
  localparam logic [7:0] OP_WLEN_D     = 8'h89;
  localparam logic [7:0] OP_RLEN_D     = 8'h8A;
  localparam logic [7:0] OP_GET_WLEN   = 8'h8B;
  localparam logic [7:0] OP_GET_RLEN   = 8'h8C;
  localparam logic [7:0] OP_GET_ID     = 8'h8D;
  localparam logic [7:0] OP_GET_BCHAR  = 8'h8E;
  localparam logic [7:0] OP_GET_DCHAR  = 8'h8F;
  localparam logic [7:0] OP_GET_STAT   = 8'h90;

  typedef struct packed {
    logic hj;
    logic ibi;
  } evt_en_t;

  localparam int EVT_IBI_BIT = 0;
  localparam int EVT_HJ_BIT  = 3;

  function automatic logic code_supported(input logic [7:0] c);
    logic r;
    case (c)
      8'h00, 8'h01, 8'h06, 8'h07, 8'h09, 8'h0A, 8'h0C, 8'h2A,
      8'h80, 8'h81, 8'h86, 8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C,
      8'h8D, 8'h8E, 8'h8F, 8'h90, 8'h94, 8'h9A: r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ccc_front.sv
module ccc_front
  import i3c_ccc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_code,
  input  logic              addr_hit,
  input  logic              xfer_end,
  input  logic              sa_hit_in,
  input  logic              da_hit_in,
  output logic              cmd_take,
  output logic [BYTE_W-1:0] code_q,
  output logic              take_q,
  output logic              sup_irq,
  output logic              unsup_irq,
  output logic              sa_flag,
  output logic              da_flag
);

  logic [BYTE_W-1:0] code_d;
  logic              take_d, active_d, active_q;
  logic              sup_d, unsup_d, sa_d, da_d;
  logic              is_sup;

  assign is_sup   = code_supported(cmd_code);
  // bit 7 separates bus-wide from addressed codes
  assign cmd_take = cmd_valid & (~cmd_code[BYTE_W-1] | addr_hit);

  always_comb begin
    code_d   = code_q;
    take_d   = take_q;
    active_d = active_q;
    if (cmd_valid) begin
      code_d   = cmd_code;
      take_d   = cmd_take;
      active_d = 1'b1;
    end else if (xfer_end) begin
      take_d   = 1'b0;
      active_d = 1'b0;
    end
    sup_d   = cmd_take & is_sup;
    unsup_d = cmd_take & ~is_sup;
    sa_d    = sa_hit_in & ~active_q & ~cmd_valid;
    da_d    = da_hit_in & ~active_q & ~cmd_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= '0;
      take_q    <= 1'b0;
      active_q  <= 1'b0;
      sup_irq   <= 1'b0;
      unsup_irq <= 1'b0;
      sa_flag   <= 1'b0;
      da_flag   <= 1'b0;
    end else begin
      code_q    <= code_d;
      take_q    <= take_d;
      active_q  <= active_d;
      sup_irq   <= sup_d;
      unsup_irq <= unsup_d;
      sa_flag   <= sa_d;
      da_flag   <= da_d;
    end
  end

  assert_code_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> code_q == $past(cmd_code));

  assert_one_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sup_irq && unsup_irq));

  assert_direct_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[BYTE_W-1] && !addr_hit) |=> (!sup_irq && !unsup_irq));

  assert_match_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q || cmd_valid) |=> (!sa_flag && !da_flag));

endmodule

// File: rtl/ccc_cfg_regs.sv
module ccc_cfg_regs
  import i3c_ccc_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter int          LEN_W    = 16,
  parameter logic [15:0] RLEN_RST = 16'h0100,
  parameter logic [15:0] WLEN_RST = 16'h0100,
  parameter logic [7:0]  PSZ_RST  = 8'h00,
  parameter logic        IBI_RST  = 1'b1,
  parameter logic        HJ_RST   = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_code,
  input  logic              cmd_take,
  input  logic [BYTE_W-1:0] code_q,
  input  logic              take_q,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  output evt_en_t           evt_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_ok_q,
  output logic [LEN_W-1:0]  rlen_q,
  output logic [LEN_W-1:0]  wlen_q,
  output logic [BYTE_W-1:0] psz_q
);

  localparam int LEN_BYTES = LEN_W / BYTE_W;
  localparam int IDX_MAX   = LEN_BYTES + 1;
  localparam int IDX_W     = $clog2(IDX_MAX + 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  evt_en_t           evt_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_ok_d;
  logic [LEN_W-1:0]  rlen_d, wlen_d;
  logic [BYTE_W-1:0] psz_d;
  logic              wr_en;
  int                k;

  assign wr_en = wr_valid & take_q;
  assign k     = int'(idx_q);

  always_comb begin
    idx_d     = idx_q;
    evt_d     = evt_q;
    addr_d    = addr_q;
    addr_ok_d = addr_ok_q;
    rlen_d    = rlen_q;
    wlen_d    = wlen_q;
    psz_d     = psz_q;

    if (cmd_valid) begin
      idx_d = '0;
      if (cmd_take && (cmd_code == OP_ADDR_CLR_B || cmd_code == OP_ADDR_CLR_D)) begin
        addr_d    = '0;
        addr_ok_d = 1'b0;
      end
    end else if (wr_valid) begin
      if (k < IDX_MAX) idx_d = idx_q + 1'b1;
    end

    if (wr_en) begin
      case (code_q)
        OP_EVT_ON_B, OP_EVT_ON_D: if (k == 0) begin
          evt_d.ibi = evt_q.ibi | wr_data[EVT_IBI_BIT];
          evt_d.hj  = evt_q.hj  | wr_data[EVT_HJ_BIT];
        end
        OP_EVT_OFF_B, OP_EVT_OFF_D: if (k == 0) begin
          evt_d.ibi = evt_q.ibi & ~wr_data[EVT_IBI_BIT];
          evt_d.hj  = evt_q.hj  & ~wr_data[EVT_HJ_BIT];
        end
        OP_ADDR_NEW: if (k == 0) begin
          addr_d    = wr_data[BYTE_W-1 -: ADDR_W];
          addr_ok_d = 1'b1;
        end
        OP_RLEN_B, OP_RLEN_D: begin
          if (k < LEN_BYTES)
            rlen_d[BYTE_W*(LEN_BYTES-1-k) +: BYTE_W] = wr_data;
          else if (k == LEN_BYTES)
            psz_d = wr_data;
        end
        OP_WLEN_B, OP_WLEN_D: begin
          if (k < LEN_BYTES)
            wlen_d[BYTE_W*(LEN_BYTES-1-k) +: BYTE_W] = wr_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      evt_q     <= '{hj: HJ_RST, ibi: IBI_RST};
      addr_q    <= '0;
      addr_ok_q <= 1'b0;
      rlen_q    <= RLEN_RST[LEN_W-1:0];
      wlen_q    <= WLEN_RST[LEN_W-1:0];
      psz_q     <= PSZ_RST;
    end else begin
      idx_q     <= idx_d;
      evt_q     <= evt_d;
      addr_q    <= addr_d;
      addr_ok_q <= addr_ok_d;
      rlen_q    <= rlen_d;
      wlen_q    <= wlen_d;
      psz_q     <= psz_d;
    end
  end

  assert_evt_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (code_q == OP_EVT_ON_B || code_q == OP_EVT_ON_D ||
                code_q == OP_EVT_OFF_B || code_q == OP_EVT_OFF_D)) |=> $stable(evt_q));

  assert_addr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && (cmd_code == OP_ADDR_CLR_B || cmd_code == OP_ADDR_CLR_D))
      |=> (!addr_ok_q && addr_q == '0));

  assert_addr_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && code_q == OP_ADDR_NEW && idx_q == '0)
      |=> (addr_ok_q && addr_q == $past(wr_data[BYTE_W-1 -: ADDR_W])));

  assert_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !take_q) |=> ($stable(rlen_q) && $stable(wlen_q) && $stable(psz_q)));

endmodule

// File: rtl/ccc_responder.sv
module ccc_responder
  import i3c_ccc_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int PID_BYTES = 6,
  parameter int ST_BYTES  = 2
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [BYTE_W-1:0]           code_q,
  input  logic                        take_q,
  input  logic                        rd_req,
  input  logic [BYTE_W*PID_BYTES-1:0] prov_id,
  input  logic [BYTE_W-1:0]           bus_char,
  input  logic [BYTE_W-1:0]           dev_char,
  input  logic [BYTE_W*ST_BYTES-1:0]  dev_status,
  input  logic [LEN_W-1:0]            rlen,
  input  logic [LEN_W-1:0]            wlen,
  input  logic [BYTE_W-1:0]           psz,
  output logic [BYTE_W-1:0]           rd_data,
  output logic                        rd_valid
);

  localparam int LEN_BYTES = LEN_W / BYTE_W;
  localparam int IDX_MAX   = PID_BYTES + 1;
  localparam int IDX_W     = $clog2(IDX_MAX + 1);

  logic [IDX_W-1:0]           idx_q, idx_d;
  logic [BYTE_W-1:0]          sel, data_d;
  logic [LEN_W-1:0]           lsh;
  logic [BYTE_W*PID_BYTES-1:0] psh;
  logic [BYTE_W*ST_BYTES-1:0] ssh;
  logic                       valid_d;
  int                         k;

  assign k = int'(idx_q);

  // byte k of a value sent most significant byte first
  always_comb begin
    lsh = '0;
    psh = prov_id >> (BYTE_W * (PID_BYTES - 1 - k));
    ssh = dev_status >> (BYTE_W * (ST_BYTES - 1 - k));
    sel = '0;
    if (take_q) begin
      case (code_q)
        OP_GET_WLEN: if (k < LEN_BYTES) begin
          lsh = wlen >> (BYTE_W * (LEN_BYTES - 1 - k));
          sel = lsh[BYTE_W-1:0];
        end
        OP_GET_RLEN: begin
          if (k < LEN_BYTES) begin
            lsh = rlen >> (BYTE_W * (LEN_BYTES - 1 - k));
            sel = lsh[BYTE_W-1:0];
          end else if (k == LEN_BYTES) begin
            sel = psz;
          end
        end
        OP_GET_ID:    if (k < PID_BYTES) sel = psh[BYTE_W-1:0];
        OP_GET_BCHAR: if (k == 0) sel = bus_char;
        OP_GET_DCHAR: if (k == 0) sel = dev_char;
        OP_GET_STAT:  if (k < ST_BYTES) sel = ssh[BYTE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    idx_d   = idx_q;
    data_d  = rd_data;
    valid_d = rd_req;
    if (cmd_valid) begin
      idx_d = '0;
    end else if (rd_req) begin
      data_d = sel;
      if (k < IDX_MAX) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      idx_q    <= idx_d;
      rd_data  <= data_d;
      rd_valid <= valid_d;
    end
  end

  assert_rd_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_past_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !cmd_valid && k == IDX_MAX) |=> rd_data == '0);

  assert_no_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !cmd_valid && !take_q) |=> rd_data == '0);

endmodule

// File: rtl/i3c_ccc_decoder.sv
module i3c_ccc_decoder
  import i3c_ccc_pkg::*;
#(
  parameter int          ADDR_W    = 7,
  parameter int          LEN_W     = 16,
  parameter int          PID_BYTES = 6,
  parameter int          ST_BYTES  = 2,
  parameter logic [15:0] RLEN_RST  = 16'h0100,
  parameter logic [15:0] WLEN_RST  = 16'h0100,
  parameter logic [7:0]  PSZ_RST   = 8'h00
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [7:0]                  cmd_code,
  input  logic                        addr_hit,
  input  logic                        wr_valid,
  input  logic [7:0]                  wr_data,
  input  logic                        rd_req,
  input  logic                        xfer_end,
  input  logic                        sa_hit_in,
  input  logic                        da_hit_in,
  input  logic [8*PID_BYTES-1:0]      prov_id,
  input  logic [7:0]                  bus_char,
  input  logic [7:0]                  dev_char,
  input  logic [8*ST_BYTES-1:0]       dev_status,
  output logic [7:0]                  ccc_code,
  output logic                        sup_irq,
  output logic                        unsup_irq,
  output logic                        sa_flag,
  output logic                        da_flag,
  output logic                        ibi_en,
  output logic                        hj_en,
  output logic [ADDR_W-1:0]           dyn_addr,
  output logic                        dyn_addr_valid,
  output logic [LEN_W-1:0]            max_rd_len,
  output logic [LEN_W-1:0]            max_wr_len,
  output logic [7:0]                  ibi_size,
  output logic [7:0]                  rd_data,
  output logic                        rd_valid
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic                   cmd_take, take_q;
  evt_en_t                evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  ccc_front u_front (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .addr_hit  (addr_hit),
    .xfer_end  (xfer_end),
    .sa_hit_in (sa_hit_in),
    .da_hit_in (da_hit_in),
    .cmd_take  (cmd_take),
    .code_q    (ccc_code),
    .take_q    (take_q),
    .sup_irq   (sup_irq),
    .unsup_irq (unsup_irq),
    .sa_flag   (sa_flag),
    .da_flag   (da_flag)
  );

  ccc_cfg_regs #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .RLEN_RST (RLEN_RST),
    .WLEN_RST (WLEN_RST),
    .PSZ_RST  (PSZ_RST),
    .IBI_RST  (1'b1),
    .HJ_RST   (1'b1)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_take  (cmd_take),
    .code_q    (ccc_code),
    .take_q    (take_q),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .evt_q     (evt),
    .addr_q    (dyn_addr),
    .addr_ok_q (dyn_addr_valid),
    .rlen_q    (max_rd_len),
    .wlen_q    (max_wr_len),
    .psz_q     (ibi_size)
  );

  assign ibi_en = evt.ibi;
  assign hj_en  = evt.hj;

  ccc_responder #(
    .LEN_W     (LEN_W),
    .PID_BYTES (PID_BYTES),
    .ST_BYTES  (ST_BYTES)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_valid  (cmd_valid),
    .code_q     (ccc_code),
    .take_q     (take_q),
    .rd_req     (rd_req),
    .prov_id    (prov_id),
    .bus_char   (bus_char),
    .dev_char   (dev_char),
    .dev_status (dev_status),
    .rlen       (max_rd_len),
    .wlen       (max_wr_len),
    .psz        (ibi_size),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

endmodule

// File: tb/i3c_ccc_decoder_test.sv
`timescale 1ns/1ps
module i3c_ccc_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, addr_hit, wr_valid, rd_req, xfer_end, sa_hit_in, da_hit_in;
  logic [7:0]  cmd_code, wr_data;
  logic [47:0] prov_id    = 48'h0123_4567_89AB;
  logic [7:0]  bus_char   = 8'h66;
  logic [7:0]  dev_char   = 8'hC4;
  logic [15:0] dev_status = 16'h5A0F;
  logic [7:0]  ccc_code, ibi_size, rd_data;
  logic        sup_irq, unsup_irq, sa_flag, da_flag, ibi_en, hj_en, dyn_addr_valid, rd_valid;
  logic [6:0]  dyn_addr;
  logic [15:0] max_rd_len, max_wr_len;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;
  logic got_sup, got_unsup;
  logic [7:0] rbyte;

  always #2.5 clk = ~clk;

  i3c_ccc_decoder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .addr_hit(addr_hit), .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .xfer_end(xfer_end), .sa_hit_in(sa_hit_in), .da_hit_in(da_hit_in),
    .prov_id(prov_id), .bus_char(bus_char), .dev_char(dev_char), .dev_status(dev_status),
    .ccc_code(ccc_code), .sup_irq(sup_irq), .unsup_irq(unsup_irq), .sa_flag(sa_flag),
    .da_flag(da_flag), .ibi_en(ibi_en), .hj_en(hj_en), .dyn_addr(dyn_addr),
    .dyn_addr_valid(dyn_addr_valid), .max_rd_len(max_rd_len), .max_wr_len(max_wr_len),
    .ibi_size(ibi_size), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all drive tasks start and end on a falling edge
  task automatic send_cmd(input logic [7:0] c, input logic hit);
    cmd_code = c; addr_hit = hit; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; addr_hit = 1'b0;
    got_sup = sup_irq; got_unsup = unsup_irq;
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] d);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    d = rd_data;
    check("R11 rd_valid", rd_valid, 1);
  endtask

  task automatic end_xfer();
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
  endtask

  task automatic expect_read(input string req, input logic [7:0] exp);
    logic [7:0] d;
    read_byte(d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    check("R12 ccc_code", ccc_code, 8'h00);
    check("R12 irqs", {sup_irq, unsup_irq, sa_flag, da_flag}, 0);
    check("R12 enables", {ibi_en, hj_en}, 2'b11);
    check("R12 addr", {dyn_addr_valid, dyn_addr}, 0);
    check("R12 lengths", {max_rd_len, max_wr_len, ibi_size}, {16'h0100, 16'h0100, 8'h00});
  endtask

  task automatic t_events();
    send_cmd(8'h01, 1'b0);
    check("R2 bcast disable sup", {got_sup, got_unsup}, 2'b10);
    write_byte(8'h09);
    check("R5 disable both", {ibi_en, hj_en}, 2'b00);
    end_xfer();
    send_cmd(8'h80, 1'b1);
    check("R2 direct enable sup", {got_sup, got_unsup}, 2'b10);
    write_byte(8'hF6);           // bit0 clear, bit3 clear: nothing set
    check("R5 other bits ignored", {ibi_en, hj_en}, 2'b00);
    end_xfer();
    send_cmd(8'h80, 1'b1);
    write_byte(8'h08);
    check("R5 set hj only", {ibi_en, hj_en}, 2'b01);
    end_xfer();
    send_cmd(8'h81, 1'b0);
    check("R3 direct no match no irq", {got_sup, got_unsup}, 2'b00);
    write_byte(8'h08);
    check("R3 direct no match no update", hj_en, 1'b1);
    end_xfer();
    send_cmd(8'h00, 1'b0);
    write_byte(8'h01);
    check("R5 bcast set ibi", {ibi_en, hj_en}, 2'b11);
    end_xfer();
  endtask

  task automatic t_unsupported();
    send_cmd(8'h3F, 1'b0);
    check("R1 latch unsupported", ccc_code, 8'h3F);
    check("R2 unsup bcast", {got_sup, got_unsup}, 2'b01);
    write_byte(8'h55);
    check("R8 write under other code", {max_rd_len, max_wr_len, ibi_size}, {16'h0100, 16'h0100, 8'h00});
    expect_read("R11 no response code", 8'h00);
    end_xfer();
    send_cmd(8'hA0, 1'b1);
    check("R2 unsup direct", {got_sup, got_unsup}, 2'b01);
    end_xfer();
    send_cmd(8'hC5, 1'b0);
    check("R1 latch unmatched direct", ccc_code, 8'hC5);
    check("R3 unmatched silent", {got_sup, got_unsup}, 2'b00);
    end_xfer();
    send_cmd(8'h94, 1'b1);
    check("R2 0x94 supported", {got_sup, got_unsup}, 2'b10);
    expect_read("R11 0x94 returns zero", 8'h00);
    end_xfer();
  endtask

  task automatic t_address();
    send_cmd(8'h88, 1'b1);
    write_byte(8'hA4);
    check("R7 new address", {dyn_addr_valid, dyn_addr}, {1'b1, 7'h52});
    end_xfer();
    send_cmd(8'h06, 1'b0);
    check("R6 bcast clear", {dyn_addr_valid, dyn_addr}, 8'h00);
    end_xfer();
    send_cmd(8'h88, 1'b1);
    write_byte(8'h3C);
    write_byte(8'hFE);
    check("R7 second address", {dyn_addr_valid, dyn_addr}, {1'b1, 7'h1E});
    end_xfer();
    send_cmd(8'h86, 1'b0);
    check("R3 direct clear unmatched", {dyn_addr_valid, dyn_addr}, {1'b1, 7'h1E});
    end_xfer();
    send_cmd(8'h86, 1'b1);
    check("R6 direct clear", {dyn_addr_valid, dyn_addr}, 8'h00);
    end_xfer();
  endtask

  task automatic t_lengths();
    send_cmd(8'h0A, 1'b0);
    write_byte(8'h12); write_byte(8'h34);
    check("R8 mrl two bytes", {max_rd_len, ibi_size}, {16'h1234, 8'h00});
    end_xfer();
    send_cmd(8'h8A, 1'b1);
    write_byte(8'h00); write_byte(8'h40); write_byte(8'h20); write_byte(8'h77);
    check("R8 mrl with size", {max_rd_len, ibi_size}, {16'h0040, 8'h20});
    end_xfer();
    send_cmd(8'h09, 1'b0);
    write_byte(8'hAB); write_byte(8'hCD); write_byte(8'hEE);
    check("R8 mwl extra ignored", {max_wr_len, max_rd_len, ibi_size}, {16'hABCD, 16'h0040, 8'h20});
    end_xfer();
    send_cmd(8'h8C, 1'b1);
    expect_read("R9 mrl hi", 8'h00);
    expect_read("R9 mrl lo", 8'h40);
    expect_read("R9 ibi size", 8'h20);
    expect_read("R11 past end", 8'h00);
    end_xfer();
    send_cmd(8'h8B, 1'b1);
    expect_read("R9 mwl hi", 8'hAB);
    expect_read("R9 mwl lo", 8'hCD);
    expect_read("R11 past end mwl", 8'h00);
    end_xfer();
  endtask

  task automatic t_ids();
    logic [47:0] exp_id;
    exp_id = 48'h0123_4567_89AB;
    send_cmd(8'h8D, 1'b1);
    for (int i = 0; i < 6; i++) expect_read("R10 pid byte", exp_id[8*(5-i) +: 8]);
    expect_read("R11 pid past end", 8'h00);
    expect_read("R11 pid saturate", 8'h00);
    end_xfer();
    send_cmd(8'h8D, 1'b1);
    expect_read("R10 pid restart 0", 8'h01);
    expect_read("R10 pid restart 1", 8'h23);
    send_cmd(8'h8D, 1'b1);
    expect_read("R11 counter reset", 8'h01);
    end_xfer();
    send_cmd(8'h8E, 1'b1);
    expect_read("R10 bcr", 8'h66);
    expect_read("R11 bcr past end", 8'h00);
    end_xfer();
    send_cmd(8'h8F, 1'b1);
    expect_read("R10 dcr", 8'hC4);
    end_xfer();
    send_cmd(8'h90, 1'b1);
    expect_read("R10 status hi", 8'h5A);
    expect_read("R10 status lo", 8'h0F);
    end_xfer();
    send_cmd(8'h8D, 1'b0);
    expect_read("R3 unmatched get", 8'h00);
    end_xfer();
  endtask

  task automatic t_match();
    sa_hit_in = 1'b1;
    @(negedge clk);
    sa_hit_in = 1'b0;
    check("R4 sa passes", {sa_flag, da_flag}, 2'b10);
    @(negedge clk);
    check("R4 sa pulse ends", sa_flag, 1'b0);
    sa_hit_in = 1'b1; da_hit_in = 1'b1;
    send_cmd(8'h07, 1'b0);
    check("R4 quiet with cmd", {sa_flag, da_flag}, 2'b00);
    @(negedge clk);
    check("R4 quiet in transfer", {sa_flag, da_flag}, 2'b00);
    sa_hit_in = 1'b0; da_hit_in = 1'b0;
    end_xfer();
    da_hit_in = 1'b1;
    @(negedge clk);
    da_hit_in = 1'b0;
    check("R4 da passes after end", {sa_flag, da_flag}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {cmd_valid, addr_hit, wr_valid, rd_req, xfer_end, sa_hit_in, da_hit_in} = '0;
    cmd_code = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_events();
    t_unsupported();
    t_address();
    t_lengths();
    t_ids();
    t_match();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule